// File: doc/BRIEF.md
# Byte-Count Line Framer

This block places start-of-line and end-of-line flags on the data beats of a received long packet. Line boundaries are taken only from the byte length carried in the packet header. The horizontal sync input is accepted at the port and has no effect on anything the block produces. A one-cycle header strobe loads the byte length and opens the packet. The first data beat accepted after the strobe is flagged as start-of-line. Each later beat subtracts its own count of valid bytes, and the beat that uses up the count is flagged as end-of-line, which closes the packet.

A packet that carries a whole frame with no line breaks is handled by the same counter. It simply loads a much larger length. If a new header strobe arrives while a packet is still open, the block raises a sticky error flag and starts counting again for the new packet. Beats are forwarded one register stage later, with their data and byte count unchanged.

Top module: `lfr_line_framer`

## Requirements
- R1: After reset, `out_valid_o` and `len_err_o` are 0 and no packet is open.
- R2: When `pkt_start_i` is 1, `pkt_len_i` is loaded as the packet's byte count. A beat presented in that same cycle is discarded and produces no output.
- R3: The first beat accepted after a header strobe leaves with `out_sol_o`=1. Every later beat of the same packet leaves with `out_sol_o`=0.
- R4: Each accepted beat subtracts `beat_bytes_i` (1 to DATA_W/8 valid bytes) from the remaining count. The beat whose byte count is greater than or equal to the remainder leaves with `out_eol_o`=1, and that beat closes the packet.
- R5: A beat with `beat_valid_i`=1 while no packet is open is dropped, and `out_valid_o` stays 0 for it.
- R6: An accepted beat appears on the outputs one clock after it is presented, with `out_data_o` and `out_bytes_o` equal to the input data and byte count.
- R7: A packet whose length is at most DATA_W/8 bytes, including length 0, gets both `out_sol_o` and `out_eol_o` on its single beat.
- R8: A frame-length packet, up to the largest value of the 16-bit length field (65535), gets the same start and end flags as a line-sized packet.
- R9: `hsync_i` has no effect on any output.
- R10: A header strobe arriving while a packet is open sets `len_err_o` one clock later. The new length replaces the old one, and the next accepted beat is flagged as start-of-line.
- R11: Once set, `len_err_o` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | Horizontal sync; ignored |
| pkt_start_i | input | 1 | Long packet header strobe |
| pkt_len_i | input | LEN_W (16) | Packet length in bytes |
| beat_valid_i | input | 1 | Data beat present |
| beat_data_i | input | DATA_W (32) | Beat payload |
| beat_bytes_i | input | CNT_W (3) | Valid bytes in the beat, 1..DATA_W/8 |
| out_valid_o | output | 1 | Forwarded beat present |
| out_data_o | output | DATA_W (32) | Forwarded payload |
| out_bytes_o | output | CNT_W (3) | Forwarded valid byte count |
| out_sol_o | output | 1 | Start-of-line flag |
| out_eol_o | output | 1 | End-of-line flag |
| len_err_o | output | 1 | Sticky restart error |

## Verification
The bench builds the block with its default parameters: a 32-bit data path with four byte lanes, and a 16-bit length. The 16-bit length makes the largest frame reachable, a 65535-byte packet that ends on a partial 3-byte remainder. The four lanes let the per-beat byte count take every value from 1 to 4, so the bench can drive exact finishes, beats that deliver more bytes than remain, zero-length packets and single-beat packets. The horizontal sync input is toggled at random through every run.

// File: rtl/lfr_pkg.sv
package lfr_pkg;
    parameter int unsigned LFR_DATA_W = 32;
    parameter int unsigned LFR_LEN_W  = 16;

    typedef struct packed {
        logic sol;
        logic eol;
    } lfr_mark_t;
endpackage

// File: rtl/lfr_len_counter.sv
module lfr_len_counter #(
    parameter int unsigned LEN_W = lfr_pkg::LFR_LEN_W,
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             take_i,
    input  logic [CNT_W-1:0] take_bytes_i,
    output logic             active_o,
    output logic             first_o,
    output logic             last_o
);
    typedef struct packed {
        logic             active;
        logic             first;
        logic [LEN_W-1:0] remain;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [LEN_W-1:0] take_ext;

    always_comb begin
        take_ext = LEN_W'(take_bytes_i);
        last_o   = st_q.active && (take_ext >= st_q.remain);
        st_d     = st_q;
        if (load_i) begin
            st_d.active = 1'b1;
            st_d.first  = 1'b1;
            st_d.remain = len_i;
        end else if (take_i && st_q.active) begin
            st_d.first  = 1'b0;
            st_d.active = !last_o;
            st_d.remain = last_o ? '0 : (st_q.remain - take_ext);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign first_o  = st_q.first;
endmodule

// File: rtl/lfr_out_stage.sv
module lfr_out_stage #(
    parameter int unsigned DATA_W = lfr_pkg::LFR_DATA_W,
    parameter int unsigned CNT_W  = 3
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                valid_i,
    input  logic [DATA_W-1:0]   data_i,
    input  logic [CNT_W-1:0]    bytes_i,
    input  lfr_pkg::lfr_mark_t  mark_i,
    output logic                valid_o,
    output logic [DATA_W-1:0]   data_o,
    output logic [CNT_W-1:0]    bytes_o,
    output lfr_pkg::lfr_mark_t  mark_o
);
    typedef struct packed {
        logic               valid;
        logic [DATA_W-1:0]  data;
        logic [CNT_W-1:0]   bytes;
        lfr_pkg::lfr_mark_t mark;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = valid_i;
        if (valid_i) begin
            st_d.data  = data_i;
            st_d.bytes = bytes_i;
            st_d.mark  = mark_i;
        end else begin
            st_d.mark  = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign data_o  = st_q.data;
    assign bytes_o = st_q.bytes;
    assign mark_o  = st_q.mark;
endmodule

// File: rtl/lfr_line_framer.sv
module lfr_line_framer #(
    parameter  int unsigned DATA_W = lfr_pkg::LFR_DATA_W,
    parameter  int unsigned LEN_W  = lfr_pkg::LFR_LEN_W,
    localparam int unsigned LANES  = DATA_W / 8,
    localparam int unsigned CNT_W  = $clog2(LANES + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              hsync_i,
    input  logic              pkt_start_i,
    input  logic [LEN_W-1:0]  pkt_len_i,
    input  logic              beat_valid_i,
    input  logic [DATA_W-1:0] beat_data_i,
    input  logic [CNT_W-1:0]  beat_bytes_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_data_o,
    output logic [CNT_W-1:0]  out_bytes_o,
    output logic              out_sol_o,
    output logic              out_eol_o,
    output logic              len_err_o
);
    typedef struct packed {
        logic err;
    } top_st_t;

    top_st_t            st_d, st_q;
    logic               cnt_active;
    logic               cnt_first;
    logic               cnt_last;
    logic               take;
    lfr_pkg::lfr_mark_t mark_in;
    lfr_pkg::lfr_mark_t mark_out;

    lfr_len_counter #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_cnt (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .load_i       (pkt_start_i),
        .len_i        (pkt_len_i),
        .take_i       (take),
        .take_bytes_i (beat_bytes_i),
        .active_o     (cnt_active),
        .first_o      (cnt_first),
        .last_o       (cnt_last)
    );

    always_comb begin
        take        = beat_valid_i && !pkt_start_i && cnt_active;
        mark_in.sol = cnt_first;
        mark_in.eol = cnt_last;
        st_d        = st_q;
        if (pkt_start_i && cnt_active) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    lfr_out_stage #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_out (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .valid_i (take),
        .data_i  (beat_data_i),
        .bytes_i (beat_bytes_i),
        .mark_i  (mark_in),
        .valid_o (out_valid_o),
        .data_o  (out_data_o),
        .bytes_o (out_bytes_o),
        .mark_o  (mark_out)
    );

    assign out_sol_o = mark_out.sol;
    assign out_eol_o = mark_out.eol;
    assign len_err_o = st_q.err;
endmodule

// File: rtl/lfr_line_framer_chk.sv
module lfr_line_framer_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic hsync_i,
    input logic pkt_start_i,
    input logic beat_valid_i,
    input logic cnt_active,
    input logic out_valid_o,
    input logic out_sol_o,
    input logic out_eol_o,
    input logic len_err_o
);
    a_r2_start_beat_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pkt_start_i |=> !out_valid_o);

    a_r5_idle_beat_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cnt_active && !pkt_start_i) |=> !out_valid_o);

    a_r4_eol_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_eol_o |-> !cnt_active);

    a_r3_sol_on_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_sol_o |-> out_valid_o);

    a_r9_hsync_no_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hsync_i && !beat_valid_i) |=> !out_valid_o);

    a_r10_restart_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pkt_start_i && cnt_active) |=> len_err_o);

    a_r11_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        len_err_o |=> len_err_o);
endmodule

bind lfr_line_framer lfr_line_framer_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hsync_i      (hsync_i),
    .pkt_start_i  (pkt_start_i),
    .beat_valid_i (beat_valid_i),
    .cnt_active   (cnt_active),
    .out_valid_o  (out_valid_o),
    .out_sol_o    (out_sol_o),
    .out_eol_o    (out_eol_o),
    .len_err_o    (len_err_o)
);

// File: tb/tb_lfr_line_framer.sv
module tb_lfr_line_framer;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        hsync_i = 1'b0;
    logic        pkt_start_i = 1'b0;
    logic [15:0] pkt_len_i = '0;
    logic        beat_valid_i = 1'b0;
    logic [31:0] beat_data_i = '0;
    logic [2:0]  beat_bytes_i = 3'd1;
    logic        out_valid_o;
    logic [31:0] out_data_o;
    logic [2:0]  out_bytes_o;
    logic        out_sol_o;
    logic        out_eol_o;
    logic        len_err_o;

    lfr_line_framer dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .hsync_i(hsync_i),
        .pkt_start_i(pkt_start_i), .pkt_len_i(pkt_len_i),
        .beat_valid_i(beat_valid_i), .beat_data_i(beat_data_i),
        .beat_bytes_i(beat_bytes_i), .out_valid_o(out_valid_o),
        .out_data_o(out_data_o), .out_bytes_o(out_bytes_o),
        .out_sol_o(out_sol_o), .out_eol_o(out_eol_o), .len_err_o(len_err_o)
    );

    always #10 clk_i = ~clk_i;

    typedef struct {
        logic [31:0] data;
        int          bytes;
        bit          sol;
        bit          eol;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    int   stray = 0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // hsync toggles at random for the whole run (R9)
    initial begin
        forever begin
            @(negedge clk_i);
            hsync_i = 1'($urandom_range(0, 1));
        end
    end

    // monitor: pops expected beats and compares
    initial begin
        forever begin
            @(negedge clk_i);
            if (mon_on && out_valid_o) begin
                if (exp_q.size() == 0) begin
                    stray++;
                    check(1'b0, "R5", "unexpected out_valid_o", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(out_data_o == e.data, "R6", "data", out_data_o, e.data);
                    check(int'(out_bytes_o) == e.bytes, "R6", "bytes", out_bytes_o, e.bytes);
                    check(out_sol_o == e.sol, e.req, "sol", out_sol_o, e.sol);
                    check(out_eol_o == e.eol, e.req, "eol", out_eol_o, e.eol);
                end
            end
        end
    end

    function automatic int pick_bytes(input int mode, input int i);
        if (mode == 0) return 4;
        if (mode == 1) return (i % 4) + 1;
        return $urandom_range(1, 4);
    endfunction

    // header strobe with a junk beat on the same cycle (discarded, R2)
    task automatic start_pkt(input int len);
        @(negedge clk_i);
        pkt_start_i  = 1'b1;
        pkt_len_i    = 16'(len);
        beat_valid_i = 1'b1;
        beat_bytes_i = 3'd4;
        beat_data_i  = $urandom;
    endtask

    // drives beats until the expected end and pushes the expected items
    task automatic send_beats(input int len, input int mode, input string req,
                              input bit gaps, input int max_beats);
        int  rem;
        bit  first;
        bit  fin;
        int  i;
        rem   = len;
        first = 1'b1;
        fin   = 1'b0;
        i     = 0;
        @(negedge clk_i);
        pkt_start_i = 1'b0;
        beat_valid_i = 1'b0;
        while (!fin && i < max_beats) begin
            exp_t e;
            int   b;
            if (gaps && $urandom_range(0, 3) == 0) begin
                beat_valid_i = 1'b0;
                @(negedge clk_i);
            end
            b = pick_bytes(mode, i);
            beat_valid_i = 1'b1;
            beat_bytes_i = 3'(b);
            beat_data_i  = $urandom;
            e.data  = beat_data_i;
            e.bytes = b;
            e.sol   = first;
            e.eol   = (b >= rem);
            e.req   = req;
            exp_q.push_back(e);
            fin   = e.eol;
            rem   = rem - b;
            first = 1'b0;
            i++;
            @(negedge clk_i);
        end
        beat_valid_i = 1'b0;
    endtask

    task automatic send_pkt(input int len, input int mode, input string req, input bit gaps);
        start_pkt(len);
        send_beats(len, mode, req, gaps, 1 << 20);
    endtask

    task automatic drain();
        repeat (3) @(negedge clk_i);
        check(exp_q.size() == 0, "R4", "pending expected beats", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        check(out_valid_o == 1'b0, "R1", "out_valid_o in reset", out_valid_o, 0);
        check(len_err_o == 1'b0, "R1", "len_err_o in reset", len_err_o, 0);
        rst_ni = 1'b1;
        mon_on = 1'b1;

        // R1, R5: beats before any header are dropped
        repeat (4) begin
            @(negedge clk_i);
            beat_valid_i = 1'b1;
            beat_data_i  = $urandom;
            beat_bytes_i = 3'd4;
        end
        @(negedge clk_i);
        beat_valid_i = 1'b0;
        drain();
        check(stray == 0, "R1", "beats accepted with no open packet", stray, 0);

        // R3, R4, R6: line packets with several byte patterns
        send_pkt(16, 0, "R3", 1'b0);
        send_pkt(23, 1, "R4", 1'b1);
        send_pkt(101, 2, "R4", 1'b1);
        send_pkt(5, 0, "R4", 1'b0);        // last beat delivers more than remains
        drain();

        // R7: short packets
        send_pkt(4, 0, "R7", 1'b0);
        send_pkt(1, 2, "R7", 1'b0);
        send_pkt(0, 1, "R7", 1'b0);
        drain();

        // R9: a packet run while hsync keeps toggling
        send_pkt(40, 2, "R9", 1'b1);
        drain();

        // R5: beats after a closed packet are dropped
        stray = 0;
        repeat (5) begin
            @(negedge clk_i);
            beat_valid_i = 1'b1;
            beat_data_i  = $urandom;
            beat_bytes_i = 3'd2;
        end
        @(negedge clk_i);
        beat_valid_i = 1'b0;
        drain();
        check(stray == 0, "R5", "beats accepted after close", stray, 0);

        // R10: restart while open
        check(len_err_o == 1'b0, "R11", "len_err_o before restart", len_err_o, 0);
        start_pkt(20);
        send_beats(20, 0, "R3", 1'b0, 2);   // 8 of 20 bytes, packet still open
        start_pkt(8);
        @(negedge clk_i);
        check(len_err_o == 1'b1, "R10", "len_err_o after restart", len_err_o, 1);
        pkt_start_i = 1'b0;
        beat_valid_i = 1'b0;
        send_beats(8, 0, "R10", 1'b0, 1 << 20);
        drain();

        // R8: whole-frame packet at the maximum length
        send_pkt(65535, 0, "R8", 1'b0);
        send_pkt(3001, 2, "R8", 1'b1);
        drain();
        check(len_err_o == 1'b1, "R11", "len_err_o held", len_err_o, 1);

        // R1: reset clears the sticky flag
        @(negedge clk_i);
        rst_ni = 1'b0;
        @(negedge clk_i);
        @(negedge clk_i);
        check(len_err_o == 1'b0, "R1", "len_err_o after reset", len_err_o, 0);
        check(out_valid_o == 1'b0, "R1", "out_valid_o after reset", out_valid_o, 0);
        rst_ni = 1'b1;

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
            summary();
            $finish;
        end
    end
endmodule